// File: doc/BRIEF.md
# Time-Multiplexed Band Triangular Solver Cell

This block is one physical processing element that does the work of several adjacent cells of a slowed-down linear systolic array for a band lower-triangular system L·x = b. With a slow factor of K, the element holds K virtual cells. A phase counter that counts modulo K picks, every cycle, which virtual cell runs, which operation it performs and where its operands come from. One band row is processed in every K-cycle period. The first K-1 phases run inner-product steps for the sub-diagonals, farthest first, and the last phase runs the division by the main diagonal.

The partial sum moves toward the dividing virtual cell, and it starts from a value supplied by the right-hand neighbour element. The solved unknowns move the other way. Inside the element they do not use neighbour links: they sit in a small bank of feedback registers that the producing phase writes and the consuming phases read. The oldest unknown leaves the bank at the end of each row, and it goes out at once on a right-going port for the next element. Results are qualified by a one-cycle valid strobe. A valid flag given at the start of a row marks which K-cycle slots carry real rows.

Top module: `coal_cell`

## Requirements
- R1: While reset is active (synchronous, active low), and in the cycle after it is released, x_valid and fwd_valid are 0, and x_out and x_fwd are 0.
- R2: The phase counter starts at 0 after reset, advances by one on every clock and wraps from K-1 to 0. Phase 0 is the first cycle after reset is released, so a row occupies phases 0 to K-1.
- R3: In phase p (0 ≤ p ≤ K-2) of a live row, coef_in is the coefficient of sub-diagonal K-1-p. The partial sum is nbr_y_in (sampled in phase 0 only) plus the sum over p of coef_in(p)·x[i-(K-1-p)], in DW-bit two's complement. nbr_y_in outside phase 0 and rhs_in outside phase K-1 have no effect.
- R4: In phase K-1 of a live row, coef_in is the main diagonal d and rhs_in is b. The unknown is x = (b − partial sum) / d, a DW-bit signed quotient truncated toward zero.
- R5: A main diagonal of 0 yields x = 0.
- R6: x_valid is 1 for exactly the one cycle after the phase K-1 clock edge of a live row, and x_out then holds that row's unknown.
- R7: A row whose in_valid is 0 in its phase 0 is idle. It produces no x_valid or fwd_valid, leaves x_out and x_fwd unchanged, and leaves the stored unknowns unchanged for later rows.
- R8: The unknown solved in row i is used by row i+v (counting live rows only) in phase K-1-v, for 1 ≤ v ≤ K-1.
- R9: With each x_valid, fwd_valid is 1 and x_fwd carries the unknown solved K-1 live rows earlier, which is the value leaving the feedback bank.
- R10: After reset all stored unknowns are 0, so the first rows see zero for their missing predecessors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Row-live flag, sampled in phase 0 |
| coef_in | input | DW | Band coefficient for the current phase |
| rhs_in | input | DW | Right-hand side value, sampled in phase K-1 |
| nbr_y_in | input | DW | Partial sum from the right neighbour, sampled in phase 0 |
| x_out | output | DW | Last solved unknown |
| x_valid | output | 1 | One-cycle strobe for a new x_out |
| x_fwd | output | DW | Right-going unknown that leaves the feedback bank |
| fwd_valid | output | 1 | Strobe for x_fwd |

## Verification
The assertions take for granted that the stimulus is aligned with the element's own phase counter. Rows therefore start on the first cycle after reset and follow one another back to back with no gap, and a row's liveness is decided by in_valid in its phase 0 alone. The bench keeps this alignment by counting phases itself from the moment reset is released and by driving exactly K cycles per row. It fills the ignored input slots with random values, so that a design that samples them at the wrong phase is caught. Diagonals and unknowns are kept small enough that no quotient overflows, except in the cases that deliberately test truncation and the zero divisor.

// File: rtl/coal_pkg.sv
// Shared types for the coalesced solver cell.
// Assumes: nothing beyond IEEE 1800-2017.
package coal_pkg;
    // Operation selected for the current phase.
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_MAC  = 2'd1,
        OP_DIV  = 2'd2
    } op_e;
endpackage

// File: rtl/coal_phase_ctr.sv
// Phase counter modulo the slow factor. Each phase selects one virtual cell.
// Assumes: SLOW >= 2; the counter runs freely after reset.
module coal_phase_ctr #(
    parameter int SLOW = 4,
    localparam int PW = (SLOW > 2) ? $clog2(SLOW) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [PW-1:0] phase,
    output logic          last_phase
);
    localparam logic [PW-1:0] LAST = PW'(SLOW - 1);

    // Step the phase, wrapping after the last virtual cell.
    always_ff @(posedge clk) begin
        if (!rst_n)            phase <= '0;
        else if (phase == LAST) phase <= '0;
        else                   phase <= phase + 1'b1;
    end

    // Flag the dividing phase.
    assign last_phase = (phase == LAST);

    // R2: the counter wraps back to zero after the last phase
    assert_phase_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == LAST) |=> (phase == '0));
    // R2: any other phase is followed by its successor
    assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != LAST) |=> (phase == $past(phase) + 1'b1));
    // R2: the phase never leaves the range of the slow factor
    assert_phase_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase <= LAST));
endmodule

// File: rtl/coal_hist.sv
// Feedback register bank that carries solved unknowns between merged virtual
// cells. Entry v-1 holds the unknown solved v live rows ago. The dividing
// phase writes a new unknown; the inner-product phases read by index.
// Assumes: the shift enable is raised only in the dividing phase of a live row.
module coal_hist #(
    parameter int SLOW = 4,
    parameter int DW   = 16,
    localparam int DEPTH = SLOW - 1,
    localparam int PW    = (SLOW > 2) ? $clog2(SLOW) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_en,
    input  logic signed [DW-1:0] din,
    input  logic [PW-1:0]        rd_idx,
    output logic signed [DW-1:0] rd_data,
    output logic signed [DW-1:0] tail
);
    logic [DEPTH-1:0][DW-1:0] h_q;

    // Shift chain: the newest unknown enters entry 0 and the older ones move down.
    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            // Load the newest unknown.
            always_ff @(posedge clk) begin
                if (!rst_n)        h_q[g] <= '0;
                else if (shift_en) h_q[g] <= din;
            end
        end else begin : g_body
            // Age the previous entry by one row.
            always_ff @(posedge clk) begin
                if (!rst_n)        h_q[g] <= '0;
                else if (shift_en) h_q[g] <= h_q[g-1];
            end
        end
    end

    // Read port for the consuming phase; out-of-range indices read zero.
    always_comb begin
        rd_data = '0;
        if (int'(rd_idx) < DEPTH) rd_data = h_q[rd_idx];
    end

    // Oldest entry, about to leave the bank.
    assign tail = h_q[DEPTH-1];

    // R7: without a write from a live dividing phase the stored unknowns hold
    assert_hist_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(h_q));
    // R8: after a write, entry 0 holds the value the producer supplied
    assert_hist_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (h_q[0] == $past(din)));
endmodule

// File: rtl/coal_alu.sv
// Arithmetic for one virtual-cell operation: an inner-product step
// y + l*x, and a division (b - y) / d with truncation toward zero.
// Assumes: DW-bit two's complement wrap; a zero divisor gives zero.
module coal_alu #(
    parameter int DW = 16
) (
    input  logic                 first_mac,
    input  logic signed [DW-1:0] coef,
    input  logic signed [DW-1:0] xval,
    input  logic signed [DW-1:0] acc,
    input  logic signed [DW-1:0] nbr_y,
    input  logic signed [DW-1:0] rhs,
    output logic signed [DW-1:0] mac_res,
    output logic signed [DW-1:0] div_res
);
    logic signed [DW-1:0] base;
    logic signed [DW-1:0] prod;
    logic signed [DW-1:0] diff;

    // Inner-product step; the first phase starts from the neighbour's sum.
    always_comb begin
        base    = first_mac ? nbr_y : acc;
        prod    = coef * xval;
        mac_res = base + prod;
    end

    // Division by the main diagonal, guarded against a zero divisor.
    always_comb begin
        diff = rhs - acc;
        if (coef == '0) div_res = '0;
        else            div_res = diff / coef;
    end
endmodule

// File: rtl/coal_cell.sv
// Coalesced systolic cell: one physical element that runs SLOW virtual cells
// of a band lower-triangular solver in turn, one row per SLOW cycles.
// Assumes: rows are aligned to the internal phase counter from reset onward;
// in_valid is sampled only in phase 0; nbr_y_in only in phase 0; rhs_in only
// in phase SLOW-1.
module coal_cell
    import coal_pkg::*;
#(
    parameter int SLOW = 4,
    parameter int DW   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] coef_in,
    input  logic signed [DW-1:0] rhs_in,
    input  logic signed [DW-1:0] nbr_y_in,
    output logic signed [DW-1:0] x_out,
    output logic                 x_valid,
    output logic signed [DW-1:0] x_fwd,
    output logic                 fwd_valid
);
    localparam int PW = (SLOW > 2) ? $clog2(SLOW) : 1;
    localparam logic [PW-1:0] FAR_IDX = PW'(SLOW - 2);

    logic [PW-1:0]        phase;
    logic                 last_phase;
    logic                 live_q;
    logic                 live_now;
    op_e                  op;
    logic signed [DW-1:0] acc_q;
    logic signed [DW-1:0] hist_rd;
    logic signed [DW-1:0] hist_tail;
    logic [PW-1:0]        rd_idx;
    logic signed [DW-1:0] mac_res;
    logic signed [DW-1:0] div_res;
    logic                 div_fire;

    coal_phase_ctr #(.SLOW(SLOW)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (phase),
        .last_phase (last_phase)
    );

    // Liveness of the row: taken from in_valid in phase 0, held afterwards.
    assign live_now = (phase == '0) ? in_valid : live_q;

    // Remember whether the current row is live.
    always_ff @(posedge clk) begin
        if (!rst_n)            live_q <= 1'b0;
        else if (phase == '0)  live_q <= in_valid;
    end

    // Decode the operation of the active virtual cell.
    always_comb begin
        if (!live_now)       op = OP_IDLE;
        else if (last_phase) op = OP_DIV;
        else                 op = OP_MAC;
    end

    assign div_fire = (op == OP_DIV);

    // Farthest sub-diagonal runs first: phase p reads the unknown K-1-p rows back.
    assign rd_idx = FAR_IDX - phase;

    coal_hist #(.SLOW(SLOW), .DW(DW)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (div_fire),
        .din      (div_res),
        .rd_idx   (rd_idx),
        .rd_data  (hist_rd),
        .tail     (hist_tail)
    );

    coal_alu #(.DW(DW)) u_alu (
        .first_mac (phase == '0),
        .coef      (coef_in),
        .xval      (hist_rd),
        .acc       (acc_q),
        .nbr_y     (nbr_y_in),
        .rhs       (rhs_in),
        .mac_res   (mac_res),
        .div_res   (div_res)
    );

    // Partial-sum register that carries y between inner-product phases.
    always_ff @(posedge clk) begin
        if (!rst_n)            acc_q <= '0;
        else if (op == OP_MAC) acc_q <= mac_res;
    end

    // Result and right-going port, updated by the dividing phase of a live row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_out     <= '0;
            x_valid   <= 1'b0;
            x_fwd     <= '0;
            fwd_valid <= 1'b0;
        end else begin
            x_valid   <= div_fire;
            fwd_valid <= div_fire;
            if (div_fire) begin
                x_out <= div_res;
                x_fwd <= hist_tail;
            end
        end
    end

    // R6: a result strobe lasts one cycle, since rows are SLOW cycles long
    assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        x_valid |=> !x_valid);
    // R6: the strobe follows only the last phase of a row
    assert_valid_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        x_valid |-> (phase == '0));
    // R7: without a strobe the result port holds its value
    assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !x_valid |-> $stable(x_out));
    // R9: the forward port changes only together with its strobe
    assert_fwd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !fwd_valid |-> $stable(x_fwd));
endmodule

// File: tb/coal_cell_test.sv
// Bench for coal_cell: a behavioural forward-substitution model, compared
// against all four outputs on every clock.
module coal_cell_test;
    localparam int SLOW = 4;
    localparam int DW   = 16;

    typedef logic signed [DW-1:0] word_t;
    typedef word_t cvec_t [SLOW];

    logic  clk = 1'b0;
    logic  rst_n = 1'b0;
    logic  in_valid = 1'b0;
    word_t coef_in = '0;
    word_t rhs_in = '0;
    word_t nbr_y_in = '0;
    word_t x_out;
    logic  x_valid;
    word_t x_fwd;
    logic  fwd_valid;

    int errors = 0;
    int checks = 0;

    // model state: hm[v-1] is the unknown solved v live rows ago
    word_t hm [SLOW-1];
    word_t e_out, e_fwd;

    coal_cell #(.SLOW(SLOW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .coef_in(coef_in),
        .rhs_in(rhs_in), .nbr_y_in(nbr_y_in), .x_out(x_out), .x_valid(x_valid),
        .x_fwd(x_fwd), .fwd_valid(fwd_valid)
    );

    always #5 clk = ~clk;

    task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag,
                     $signed(act), $signed(exp), $time);
        end
    endtask

    function automatic word_t model_acc(cvec_t cf, word_t y);
        word_t a = y;
        for (int p = 0; p < SLOW - 1; p++) a = a + cf[p] * hm[SLOW-2-p];
        return a;
    endfunction

    task automatic model_reset();
        for (int v = 0; v < SLOW - 1; v++) hm[v] = '0;
        e_out = '0;
        e_fwd = '0;
    endtask

    // Drive one row of SLOW phases and compare the outputs after every clock.
    task automatic do_row(bit live, cvec_t cf, word_t y, word_t rhs, string tag);
        word_t a, xn, fw;
        a  = model_acc(cf, y);
        xn = (cf[SLOW-1] == '0) ? word_t'(0) : word_t'((rhs - a) / cf[SLOW-1]);
        fw = hm[SLOW-2];
        for (int p = 0; p < SLOW; p++) begin
            in_valid = (p == 0) ? live : 1'($urandom_range(0, 1));
            coef_in  = cf[p];
            nbr_y_in = (p == 0) ? y : word_t'($urandom_range(0, 999));
            rhs_in   = (p == SLOW - 1) ? rhs : word_t'($urandom_range(0, 999));
            @(posedge clk);
            @(negedge clk);
            if (p == SLOW - 1 && live) begin
                e_out = xn;
                e_fwd = fw;
                for (int v = SLOW - 2; v > 0; v--) hm[v] = hm[v-1];
                hm[0] = xn;
            end
            chk({tag, " x_valid R6"}, 16'(x_valid), 16'(p == SLOW - 1 && live));
            chk({tag, " fwd_valid R9"}, 16'(fwd_valid), 16'(p == SLOW - 1 && live));
            chk({tag, " x_out R4"}, x_out, e_out);
            chk({tag, " x_fwd R9"}, x_fwd, e_fwd);
        end
    endtask

    // Row with a chosen target unknown: the rhs is built so the quotient is exact.
    task automatic target_row(word_t xt, word_t y, string tag);
        cvec_t cf;
        word_t a;
        for (int p = 0; p < SLOW - 1; p++) cf[p] = word_t'($urandom_range(0, 6)) - 3;
        cf[SLOW-1] = word_t'($urandom_range(1, 4));
        if ($urandom_range(0, 1) == 1) cf[SLOW-1] = -cf[SLOW-1];
        a = model_acc(cf, y);
        do_row(1'b1, cf, y, a + cf[SLOW-1] * xt, tag);
        chk({tag, " solved value R8"}, x_out, xt);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        model_reset();
        chk("reset x_valid R1", 16'(x_valid), 16'd0);
        chk("reset fwd_valid R1", 16'(fwd_valid), 16'd0);
        chk("reset x_out R1", x_out, 16'd0);
        chk("reset x_fwd R1", x_fwd, 16'd0);
        rst_n = 1'b1;
    endtask

    initial begin
        cvec_t cf;
        word_t tx [SLOW-1];
        apply_reset();

        // R10: first row after reset sees zero history, R2 alignment at phase 0
        cf = '{word_t'(5), word_t'(-2), word_t'(7), word_t'(3)};
        do_row(1'b1, cf, word_t'(0), word_t'(12), "R10 first row");
        chk("R10 zero history quotient", x_out, 16'd4);

        // R3 R8: a band system with random coefficients and a neighbour sum
        for (int i = 0; i < 30; i++)
            target_row(word_t'($urandom_range(0, 40)) - 20,
                       word_t'($urandom_range(0, 20)) - 10, "R3 band");

        // R7: idle slots interleaved with live rows must not disturb state
        for (int i = 0; i < 6; i++) begin
            cf = '{word_t'(9), word_t'(9), word_t'(9), word_t'(9)};
            do_row(1'b0, cf, word_t'(77), word_t'(55), "R7 idle");
            target_row(word_t'(i) - 3, word_t'(1), "R7 after idle");
        end

        // R4: truncation toward zero for both signs
        cf = '{word_t'(0), word_t'(0), word_t'(0), word_t'(2)};
        do_row(1'b1, cf, word_t'(0), word_t'(7), "R4 positive trunc");
        chk("R4 7/2", x_out, 16'd3);
        do_row(1'b1, cf, word_t'(0), word_t'(-7), "R4 negative trunc");
        chk("R4 -7/2", x_out, 16'(-3));

        // R5: zero main diagonal yields zero and that zero enters the history
        cf = '{word_t'(1), word_t'(1), word_t'(1), word_t'(0)};
        do_row(1'b1, cf, word_t'(4), word_t'(100), "R5 zero divisor");
        chk("R5 zero result", x_out, 16'd0);

        // R9: known sequence, then the forward port must release it in order
        apply_reset();
        for (int i = 0; i < SLOW - 1; i++) begin
            tx[i] = word_t'(10 + i);
            target_row(tx[i], word_t'(0), "R9 fill");
        end
        for (int i = 0; i < SLOW - 1; i++) begin
            target_row(word_t'(-5 - i), word_t'(2), "R9 drain");
            chk("R9 forwarded order", x_fwd, tx[i]);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R2: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule